// File: doc/BRIEF.md
# Mod-3 Residue-Checked Arithmetic Unit with Retry

This unit adds, subtracts or multiplies two N-bit operands. A residue code modulo 3 checks every attempt while it runs. The caller supplies each operand together with its residue mod 3. On a start strobe the unit latches the operation and both operands. It computes the raw result on one path. On a separate path it forms the predicted residue of that result from the operand residues alone. A third path reduces the raw result to its own residue. If the predicted and actual residues agree, the result is published with a one-cycle done pulse.

If the two residues disagree, the unit discards the attempt and runs the latched operation again, so a temporary fault gets a fresh chance. The number of retries is a parameter. When every retry also fails, the unit still publishes the last result with done, and it raises a permanent-error flag. A test port can XOR a mask onto the raw result, either for the first attempt only or for every attempt. This lets a bench exercise both the recovery path and the give-up path. The protection costs three small residue circuits instead of a second copy of the datapath.

Top module: `rcd_unit`

## Requirements
- R1: After synchronous reset, done, perm_err and busy are 0 and result and result_res are 0.
- R2: With op_sel = 2'b00 (add; 2'b11 also adds), result equals (a_in + b_in) mod 2^N, zero-extended to 2N bits. done is high in the second cycle after the edge that samples start.
- R3: With op_sel = 2'b01 (subtract), result equals (a_in - b_in) mod 2^N, zero-extended to 2N bits, with the same latency as R2.
- R4: With op_sel = 2'b10 (multiply), result equals the full 2N-bit product a_in * b_in, with the same latency as R2.
- R5: Whenever done is high, result_res equals result mod 3.
- R6: A carry out of an add or a borrow out of a subtract causes no false detection: such an operation completes at the R2 latency with perm_err 0.
- R7: With inj_en = 1 and inj_hold = 0 at start, and a mask that changes the result's value mod 3, exactly one retry occurs. done comes one cycle later than in R2, the result is fault-free and perm_err is 0.
- R8: With inj_en = 1 and inj_hold = 1, the unit retries MAX_RETRY times, then asserts done together with perm_err = 1, MAX_RETRY cycles later than in R2. result holds the corrupted value and perm_err stays 1 until the next accepted start.
- R9: While busy is 1, start and new operand, operation or injection inputs are ignored; a retry reuses the operands latched at the accepted start.
- R10: done is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation when idle |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 add |
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| a_res | input | 2 | a_in mod 3 |
| b_res | input | 2 | b_in mod 3 |
| inj_en | input | 1 | Arm fault injection for this operation |
| inj_hold | input | 1 | Keep injecting on every attempt |
| inj_mask | input | 2N | Bits XORed onto the raw result while injecting |
| result | output | 2N | Published result |
| result_res | output | 2 | Residue mod 3 of result |
| done | output | 1 | One-cycle completion pulse |
| perm_err | output | 1 | Retries exhausted without a clean check |
| busy | output | 1 | Operation in progress |

## Verification
Plain operands with no wrap show that each operation selects the right arithmetic and finishes at the base latency. Operands that overflow the add, underflow the subtract and fill the product width separate a correct carry and borrow correction from one that raises false mismatches, which would show up as extra latency or a permanent error. A single-shot injected fault against a held one separates recovery from giving up. Both cases are told apart by latency, the flag and the corrupted versus clean value. A start issued during a retry, carrying different operands, tells whether the latched inputs really are frozen.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_ALT = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } st_e;

    typedef struct packed {
        logic [1:0] pred;
        logic [1:0] actual;
        logic       mismatch;
    } chk_t;

    // reduce a small value (0..15) to its residue mod 3
    function automatic logic [1:0] mod3_small(input logic [3:0] v);
        logic [3:0] r;
        r = v % 4'd3;
        return r[1:0];
    endfunction

endpackage

// File: rtl/rcd_residue.sv
module rcd_residue
    import rcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [1:0]   res
);
    localparam int PAIRS = (W + 1) / 2;

    logic [2*PAIRS-1:0] padded;
    logic [1:0]         acc;

    // each 2-bit chunk weighs 4^k, and 4 is 1 mod 3, so chunks simply add
    always_comb begin
        padded = '0;
        padded[W-1:0] = val;
        acc = 2'd0;
        for (int i = 0; i < PAIRS; i++) begin
            acc = mod3_small({2'b00, acc} + {2'b00, padded[2*i +: 2]});
        end
        res = acc;
    end
endmodule

// File: rtl/rcd_alu.sv
module rcd_alu
    import rcd_pkg::*;
#(
    parameter int N = 8
) (
    input  op_e            op,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] raw,
    output logic           wrap
);
    logic [N:0]     sum;
    logic [N:0]     diff;
    logic [2*N-1:0] prod;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign diff = {1'b0, a} - {1'b0, b};
    assign prod = (2*N)'(a) * (2*N)'(b);

    always_comb begin
        raw  = '0;
        wrap = 1'b0;
        case (op)
            OP_SUB: begin
                raw[N-1:0] = diff[N-1:0];
                wrap       = diff[N];
            end
            OP_MUL: begin
                raw = prod;
            end
            default: begin
                raw[N-1:0] = sum[N-1:0];
                wrap       = sum[N];
            end
        endcase
    end
endmodule

// File: rtl/rcd_predict.sv
module rcd_predict
    import rcd_pkg::*;
#(
    parameter int N = 8
) (
    input  op_e        op,
    input  logic [1:0] ra,
    input  logic [1:0] rb,
    input  logic       wrap,
    output logic [1:0] pred
);
    // weight of the dropped bit 2^N, taken mod 3
    localparam logic [1:0] P2 = (N % 2 == 0) ? 2'd1 : 2'd2;

    logic [1:0] base;

    always_comb begin
        base = 2'd0;
        pred = 2'd0;
        case (op)
            OP_SUB: begin
                base = mod3_small({2'b00, ra} + 4'd3 - {2'b00, rb});
                pred = wrap ? mod3_small({2'b00, base} + {2'b00, P2}) : base;
            end
            OP_MUL: begin
                pred = mod3_small({2'b00, ra} * {2'b00, rb});
            end
            default: begin
                base = mod3_small({2'b00, ra} + {2'b00, rb});
                pred = wrap ? mod3_small({2'b00, base} + 4'd3 - {2'b00, P2}) : base;
            end
        endcase
    end
endmodule

// File: rtl/rcd_unit.sv
module rcd_unit
    import rcd_pkg::*;
#(
    parameter int N         = 8,
    parameter int MAX_RETRY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op_sel,
    input  logic [N-1:0]     a_in,
    input  logic [N-1:0]     b_in,
    input  logic [1:0]       a_res,
    input  logic [1:0]       b_res,
    input  logic             inj_en,
    input  logic             inj_hold,
    input  logic [2*N-1:0]   inj_mask,
    output logic [2*N-1:0]   result,
    output logic [1:0]       result_res,
    output logic             done,
    output logic             perm_err,
    output logic             busy
);
    localparam int RW = 2 * N;
    localparam int CW = $clog2(MAX_RETRY + 2);

    st_e            state;
    op_e            op_q;
    logic [N-1:0]   a_q, b_q;
    logic [1:0]     ra_q, rb_q;
    logic           inj_pend, inj_sticky;
    logic [RW-1:0]  mask_q;
    logic [CW-1:0]  tries;

    logic [RW-1:0]  raw_clean, raw;
    logic           wrap;
    chk_t           chk;

    rcd_alu #(.N(N)) u_alu (
        .op   (op_q),
        .a    (a_q),
        .b    (b_q),
        .raw  (raw_clean),
        .wrap (wrap)
    );

    assign raw = raw_clean ^ (inj_pend ? mask_q : '0);

    rcd_residue #(.W(RW)) u_res (
        .val (raw),
        .res (chk.actual)
    );

    rcd_predict #(.N(N)) u_pred (
        .op   (op_q),
        .ra   (ra_q),
        .rb   (rb_q),
        .wrap (wrap),
        .pred (chk.pred)
    );

    assign chk.mismatch = (chk.actual != chk.pred);
    assign busy         = (state == ST_EXEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            op_q       <= OP_ADD;
            a_q        <= '0;
            b_q        <= '0;
            ra_q       <= '0;
            rb_q       <= '0;
            inj_pend   <= 1'b0;
            inj_sticky <= 1'b0;
            mask_q     <= '0;
            tries      <= '0;
            result     <= '0;
            result_res <= '0;
            done       <= 1'b0;
            perm_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q       <= op_e'(op_sel);
                        a_q        <= a_in;
                        b_q        <= b_in;
                        ra_q       <= a_res;
                        rb_q       <= b_res;
                        inj_pend   <= inj_en;
                        inj_sticky <= inj_en & inj_hold;
                        mask_q     <= inj_mask;
                        tries      <= '0;
                        perm_err   <= 1'b0;
                        state      <= ST_EXEC;
                    end
                end
                default: begin
                    if (!chk.mismatch) begin
                        result     <= raw;
                        result_res <= chk.actual;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (tries < CW'(MAX_RETRY)) begin
                        tries    <= tries + CW'(1);
                        inj_pend <= inj_sticky;
                    end else begin
                        result     <= raw;
                        result_res <= chk.actual;
                        perm_err   <= 1'b1;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the retry counter never passes its limit
    assert_retry_bound_R8: assert property (@(posedge clk) disable iff (rst)
        tries <= CW'(MAX_RETRY));

    // R8: the error flag only appears together with completion
    assert_perm_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(perm_err) |-> done);

    // R9: latched operands stay frozen across retries
    assert_operands_held_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |=> (state == ST_IDLE) ||
            ($stable(a_q) && $stable(b_q) && $stable(op_q) && $stable(ra_q) && $stable(rb_q)));

    // R7: a clean check finishes next cycle without an error flag
    assert_clean_finish_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !chk.mismatch) |=> (done && !perm_err));

endmodule

// File: tb/tb_rcd_unit.sv
module tb_rcd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int RW   = 2 * N;
    localparam int MAXR = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [1:0]    op_sel;
    logic [N-1:0]  a_in, b_in;
    logic [1:0]    a_res, b_res;
    logic          inj_en, inj_hold;
    logic [RW-1:0] inj_mask;
    logic [RW-1:0] result;
    logic [1:0]    result_res;
    logic          done, perm_err, busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcd_unit #(.N(N), .MAX_RETRY(MAXR)) dut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .a_in(a_in), .b_in(b_in), .a_res(a_res), .b_res(b_res),
        .inj_en(inj_en), .inj_hold(inj_hold), .inj_mask(inj_mask),
        .result(result), .result_res(result_res), .done(done),
        .perm_err(perm_err), .busy(busy)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] model(input logic [1:0] op, input int a, input int b);
        case (op)
            2'b01:   return RW'((a - b) & ((1 << N) - 1));
            2'b10:   return RW'(a * b);
            default: return RW'((a + b) & ((1 << N) - 1));
        endcase
    endfunction

    task automatic launch(input logic [1:0] op, input int a, input int b,
                          input logic ie, input logic ih, input logic [RW-1:0] m);
        @(negedge clk);
        start = 1'b1; op_sel = op;
        a_in = N'(a); b_in = N'(b);
        a_res = 2'(a % 3); b_res = 2'(b % 3);
        inj_en = ie; inj_hold = ih; inj_mask = m;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 12);
    endtask

    task automatic run_case(input string req, input logic [1:0] op, input int a, input int b,
                            input logic ie, input logic ih, input logic [RW-1:0] m,
                            input int exp_lat, input logic exp_perm);
        int lat;
        logic [RW-1:0] exp;
        exp = model(op, a, b);
        if (ie && ih) exp = exp ^ m;
        launch(op, a, b, ie, ih, m);
        wait_done(lat);
        chk({req, " latency"}, lat, exp_lat);
        chk({req, " result"}, result, exp);
        chk("R5 residue", result_res, exp % 3);
        chk({req, " perm_err"}, perm_err, exp_perm);
        @(negedge clk);
        chk("R10 done pulse", done, 0);
        if (exp_perm) chk("R8 perm held", perm_err, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; op_sel = 2'b00; a_in = '0; b_in = '0;
        a_res = '0; b_res = '0; inj_en = 1'b0; inj_hold = 1'b0; inj_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 perm_err", perm_err, 0);
        chk("R1 busy", busy, 0);
        chk("R1 result", result, 0);
        chk("R1 result_res", result_res, 0);
    endtask

    task automatic t_plain;
        run_case("R2 add", 2'b00, 25, 17, 0, 0, '0, 2, 0);
        run_case("R2 add alt", 2'b11, 40, 2, 0, 0, '0, 2, 0);
        run_case("R3 sub", 2'b01, 100, 37, 0, 0, '0, 2, 0);
        run_case("R4 mul", 2'b10, 13, 7, 0, 0, '0, 2, 0);
        run_case("R4 mul full", 2'b10, 255, 255, 0, 0, '0, 2, 0);
    endtask

    task automatic t_wrap;
        run_case("R6 add carry", 2'b00, 200, 100, 0, 0, '0, 2, 0);
        run_case("R6 add carry max", 2'b00, 255, 255, 0, 0, '0, 2, 0);
        run_case("R6 sub borrow", 2'b01, 5, 9, 0, 0, '0, 2, 0);
        run_case("R6 sub borrow zero", 2'b01, 0, 1, 0, 0, '0, 2, 0);
    endtask

    task automatic t_single_fault;
        run_case("R7 add", 2'b00, 25, 17, 1, 0, 16'h0004, 3, 0);
        run_case("R7 mul", 2'b10, 200, 3, 1, 0, 16'h0100, 3, 0);
    endtask

    task automatic t_held_fault;
        run_case("R8 mul", 2'b10, 13, 7, 1, 1, 16'h0010, 2 + MAXR, 1);
        // next clean start clears the flag
        run_case("R8 clear", 2'b00, 1, 1, 0, 0, '0, 2, 0);
    endtask

    task automatic t_busy_ignore;
        int lat;
        launch(2'b00, 10, 20, 1, 0, 16'h0001);
        @(negedge clk);
        chk("R9 busy", busy, 1);
        start = 1'b1; op_sel = 2'b10; a_in = 8'd99; b_in = 8'd3;
        a_res = 2'd0; b_res = 2'd0; inj_en = 1'b0;
        lat = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk("R9 latency", lat, 3);
        chk("R9 result", result, 30);
        chk("R9 perm_err", perm_err, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no extra op", done | busy, 0);
        end
    endtask

    initial begin
        t_reset();
        t_plain();
        t_wrap();
        t_single_fault();
        t_held_fault();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule